// File: doc/BRIEF.md
# Dual Autoreload Counter Timer with Forced Overflow

This block holds two 12-bit up-counters. Each one counts one step per clock and, after it reaches the all-ones value, loads its own reload value on the next step. Software can force either counter to all-ones with a single register write, which brings on an overflow early. A self-clearing force bit records that a forced overflow is still pending. The second counter has an overflow flag that is cleared by reading it, an interrupt enable, and a run switch. While the switch is off the counter holds its value, and when the switch comes back on it continues from that value.

Four PWM outputs compare a selected count against four duty inputs. Channels 0 and 1 always use counter 1. Channels 2 and 3 use counter 2 while it is enabled, and counter 1 otherwise. A break input forces PWM pairs low. Two break-enable bits decide which pairs the break reaches, and the run switch of counter 2 decides which of the two bits governs the second pair.

Top module: `dual_reload_timer`

## Requirements
- R1: Each counter adds one per clock while running. When it is at 0xFFF, the next clock loads its reload register (address 1 for counter 1, address 2 for counter 2) and does not wrap to 0.
- R2: A write to control (address 0) with bit 3 set loads 0xFFF into counter 1 at that clock edge. Bit 4 does the same for counter 2. The counts can be read at address 4 (counter 1) and address 5 (counter 2).
- R3: A force bit reads back as 1 in control bit 3 or bit 4 from the forcing write onward. Hardware clears it one clock after that counter's overflow. Writing 0 to a force bit has no effect.
- R4: Control bit 2 is the counter-2 overflow flag. Hardware sets it when counter 2 goes from 0xFFF to its reload value. A read of address 0 with the read strobe returns the flag as 1 and clears it at that clock edge.
- R5: `irq` is high exactly while the overflow flag and control bit 1 (overflow interrupt enable) are both 1.
- R6: While control bit 0 (counter-2 run) is 0, counter 2 holds its value. After the bit is set again, counter 2 continues upward from the held value.
- R7: The break-enable register (address 3) resets to 0x003. Bit 0 enables break for the first pair and bit 1 for the second. All higher bits always read 0.
- R8: Channels 2 and 3 compare against counter 2 when control bit 0 is 1, and against counter 1 when it is 0. Channels 0 and 1 always compare against counter 1.
- R9: A PWM channel outputs 1 while its selected count is below its 12-bit duty input, and 0 otherwise.
- R10: While `brk_in` is high, channels 0 and 1 are driven 0 if break-enable bit 0 is 1. Channels 2 and 3 are driven 0 if break-enable bit 1 is 1 (counter 2 running) or bit 0 is 1 (counter 2 stopped).
- R11: The control register resets to 0x03: counter 2 running, interrupt enable set, flag and force bits 0. Both counters and both reload registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects) |
| addr | input | 3 | Register address |
| wdata | input | 12 | Write data |
| rdata | output | 12 | Read data for `addr`, combinational |
| duty | input | 48 | Four 12-bit duty values, channel 0 in the low bits |
| brk_in | input | 1 | Break active |
| pwm | output | 4 | PWM outputs, channel 0 in bit 0 |
| irq | output | 1 | Counter-2 overflow interrupt |

## Verification
The hardest state to reach is a forced overflow that lands on the same clocks as another register write. In that case the force bit must outlive the overflow clock and then clear exactly one clock later, even though a write of 0 to it arrives in between. The bench forces a counter and writes control again at the very next edge, so the overflow and the ignored clear land on the same clock. It reads the count and the force bit back on each of the following clocks. The PWM routing is checked against both counts, read through the register port in the same low clock phase, so the expected levels come from the actual counter values.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int CW = 12;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_RLD1 = 3'd1;
  localparam logic [AW-1:0] A_RLD2 = 3'd2;
  localparam logic [AW-1:0] A_BRK  = 3'd3;
  localparam logic [AW-1:0] A_CNT1 = 3'd4;
  localparam logic [AW-1:0] A_CNT2 = 3'd5;

  localparam int B_RUN2  = 0;
  localparam int B_IE2   = 1;
  localparam int B_FLAG2 = 2;
  localparam int B_FRC1  = 3;
  localparam int B_FRC2  = 4;

  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] cur,
                                               input logic [CW-1:0] rld);
    return (cur == {CW{1'b1}}) ? rld : cur + 1'b1;
  endfunction

  function automatic logic pwm_level(input logic [CW-1:0] cnt,
                                     input logic [CW-1:0] dut);
    return cnt < dut;
  endfunction
endpackage

// File: rtl/drt_counter.sv
module drt_counter
  import drt_pkg::*;
#(
  parameter int W = CW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         force_ld,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  assign wrap = run && !force_ld && (count == ALL1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (force_ld) count <= ALL1;
    else if (run)      count <= (count == ALL1) ? reload : count + 1'b1;
  end

  AST_FORCE_ALL1: assert property (@(posedge clk) disable iff (!rst_n)
    force_ld |=> count == ALL1); // R2
  AST_RELOAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == $past(reload)); // R1
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !force_ld) |=> $stable(count)); // R6
endmodule

// File: rtl/drt_regs.sv
module drt_regs
  import drt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [CW-1:0] cnt1,
  input  logic [CW-1:0] cnt2,
  input  logic          wrap1,
  input  logic          wrap2,
  output logic          force_ld1,
  output logic          force_ld2,
  output logic          run2,
  output logic          ie2,
  output logic          flag2,
  output logic [1:0]    bren,
  output logic [CW-1:0] rld1,
  output logic [CW-1:0] rld2
);
  logic frc1_q, frc2_q;
  logic ovf_seen1, ovf_seen2;
  logic ctrl_wr, ctrl_rd;

  assign ctrl_wr   = wr_en && (addr == A_CTRL);
  assign ctrl_rd   = rd_en && (addr == A_CTRL);
  assign force_ld1 = ctrl_wr && wdata[B_FRC1];
  assign force_ld2 = ctrl_wr && wdata[B_FRC2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run2 <= 1'b1;
      ie2  <= 1'b1;
      bren <= 2'b11;
      rld1 <= '0;
      rld2 <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          run2 <= wdata[B_RUN2];
          ie2  <= wdata[B_IE2];
        end
        A_RLD1: rld1 <= wdata;
        A_RLD2: rld2 <= wdata;
        A_BRK:  bren <= wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc1_q    <= 1'b0;
      frc2_q    <= 1'b0;
      ovf_seen1 <= 1'b0;
      ovf_seen2 <= 1'b0;
      flag2     <= 1'b0;
    end else begin
      ovf_seen1 <= wrap1;
      ovf_seen2 <= wrap2;
      if (force_ld1)      frc1_q <= 1'b1;
      else if (ovf_seen1) frc1_q <= 1'b0;
      if (force_ld2)      frc2_q <= 1'b1;
      else if (ovf_seen2) frc2_q <= 1'b0;
      if (wrap2)          flag2 <= 1'b1;
      else if (ctrl_rd)   flag2 <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[B_RUN2]  = run2;
        rdata[B_IE2]   = ie2;
        rdata[B_FLAG2] = flag2;
        rdata[B_FRC1]  = frc1_q;
        rdata[B_FRC2]  = frc2_q;
      end
      A_RLD1: rdata = rld1;
      A_RLD2: rdata = rld2;
      A_BRK:  rdata[1:0] = bren;
      A_CNT1: rdata = cnt1;
      A_CNT2: rdata = cnt2;
      default: rdata = '0;
    endcase
  end

  AST_FORCE1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_seen1 && !force_ld1) |=> !frc1_q); // R3
  AST_FORCE2_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_seen2 && !force_ld2) |=> !frc2_q); // R3
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap2 |=> flag2); // R4
  AST_FLAG_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !wrap2) |=> !flag2); // R4
endmodule

// File: rtl/drt_pwm.sv
module drt_pwm
  import drt_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [CW-1:0]     cnt1,
  input  logic [CW-1:0]     cnt2,
  input  logic              run2,
  input  logic [NCH*CW-1:0] duty,
  input  logic              brk_in,
  input  logic [1:0]        bren,
  output logic [NCH-1:0]    pwm
);
  logic [NCH-1:0] raw, gate;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam bit SECOND = (ch / 2) != 0;
    logic [CW-1:0] src;
    assign src      = (SECOND && run2) ? cnt2 : cnt1;
    assign raw[ch]  = pwm_level(src, duty[ch*CW +: CW]);
    assign gate[ch] = brk_in && ((SECOND && run2) ? bren[1] : bren[0]);
    assign pwm[ch]  = raw[ch] && !gate[ch];
  end

  always_comb begin
    if (brk_in && bren[0]) AST_PAIR0_BREAK: assert (pwm[1:0] == 2'b00); // R10
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [11:0]       wdata,
  output logic [11:0]       rdata,
  input  logic [NCH*12-1:0] duty,
  input  logic              brk_in,
  output logic [NCH-1:0]    pwm,
  output logic              irq
);
  logic [CW-1:0] cnt1, cnt2, rld1, rld2;
  logic wrap1, wrap2, force_ld1, force_ld2;
  logic run2, ie2, flag2;
  logic [1:0] bren;

  drt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt1(cnt1), .cnt2(cnt2),
    .wrap1(wrap1), .wrap2(wrap2), .force_ld1(force_ld1), .force_ld2(force_ld2),
    .run2(run2), .ie2(ie2), .flag2(flag2), .bren(bren), .rld1(rld1), .rld2(rld2)
  );

  drt_counter #(.W(CW)) u_cnt1 (
    .clk(clk), .rst_n(rst_n), .run(1'b1), .force_ld(force_ld1),
    .reload(rld1), .count(cnt1), .wrap(wrap1)
  );

  drt_counter #(.W(CW)) u_cnt2 (
    .clk(clk), .rst_n(rst_n), .run(run2), .force_ld(force_ld2),
    .reload(rld2), .count(cnt2), .wrap(wrap2)
  );

  drt_pwm #(.NCH(NCH)) u_pwm (
    .cnt1(cnt1), .cnt2(cnt2), .run2(run2), .duty(duty),
    .brk_in(brk_in), .bren(bren), .pwm(pwm)
  );

  assign irq = flag2 && ie2;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> flag2 && ie2); // R5
endmodule

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [11:0] wdata = '0;
  logic [11:0] rdata;
  logic [47:0] duty = '0;
  logic        brk_in = 1'b0;
  logic [3:0]  pwm;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .duty(duty), .brk_in(brk_in),
    .pwm(pwm), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [11:0] peek(input logic [2:0] a);
    return 12'h000;
  endfunction

  task automatic look(input logic [2:0] a, output logic [11:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic rd_clear(output logic [11:0] v);
    addr = 3'd0; rd_en = 1'b1; #1; v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [3:0] exp_pwm(input logic [11:0] c1, input logic [11:0] c2,
                                         input bit run, input bit brk, input logic [1:0] be);
    logic [3:0] r;
    for (int ch = 0; ch < 4; ch++) begin
      logic [11:0] c;
      bit g;
      c = (ch >= 2 && run) ? c2 : c1;
      g = brk && ((ch >= 2 && run) ? be[1] : be[0]);
      r[ch] = (c < duty[ch*12 +: 12]) && !g;
    end
    return r;
  endfunction

  task automatic t_reset();
    logic [11:0] v;
    look(3'd0, v); check(v == 12'h003, "R11 ctrl reset", v, 12'h003);
    look(3'd3, v); check(v == 12'h003, "R7 brk reset", v, 12'h003);
    look(3'd1, v); check(v == 12'h000, "R11 reload1 reset", v, 0);
    check(irq == 1'b0, "R5 irq at reset", irq, 0);
  endtask

  task automatic t_force1();
    logic [11:0] v, a, b;
    wr(3'd1, 12'h100);
    wr(3'd0, 12'h00B);
    look(3'd4, v); check(v == 12'hFFF, "R2 force loads all-ones", v, 12'hFFF);
    look(3'd0, v); check(v[3] == 1'b1, "R3 force bit set", v[3], 1);
    tick(1);
    look(3'd4, v); check(v == 12'h100, "R1 reload after all-ones", v, 12'h100);
    look(3'd0, v); check(v[3] == 1'b1, "R3 force bit held in overflow cycle", v[3], 1);
    tick(1);
    look(3'd0, v); check(v[3] == 1'b0, "R3 force bit cleared", v[3], 0);
    look(3'd4, a); tick(3); look(3'd4, b);
    check(b == a + 12'd3, "R1 counts one per clock", b, a + 12'd3);
  endtask

  task automatic t_force_zero_ignored();
    logic [11:0] v;
    wr(3'd0, 12'h00B);
    wr(3'd0, 12'h003);
    look(3'd4, v); check(v == 12'h100, "R1 reload in same cycle as write", v, 12'h100);
    look(3'd0, v); check(v[3] == 1'b1, "R3 write of 0 ignored", v[3], 1);
    tick(1);
    look(3'd0, v); check(v[3] == 1'b0, "R3 clears one clock after overflow", v[3], 0);
  endtask

  task automatic t_flag_irq();
    logic [11:0] v;
    wr(3'd2, 12'h7F0);
    wr(3'd0, 12'h011);
    look(3'd5, v); check(v == 12'hFFF, "R2 force counter 2", v, 12'hFFF);
    tick(1);
    look(3'd5, v); check(v == 12'h7F0, "R1 counter 2 reload", v, 12'h7F0);
    look(3'd0, v); check(v[2] == 1'b1, "R4 flag set on wrap", v[2], 1);
    check(irq == 1'b0, "R5 irq masked", irq, 0);
    wr(3'd0, 12'h003);
    check(irq == 1'b1, "R5 irq flag and enable", irq, 1);
    rd_clear(v);
    check(v[2] == 1'b1, "R4 read returns flag", v[2], 1);
    look(3'd0, v); check(v[2] == 1'b0, "R4 flag cleared by read", v[2], 0);
    check(irq == 1'b0, "R5 irq drops", irq, 0);
  endtask

  task automatic t_freeze();
    logic [11:0] h, v;
    wr(3'd0, 12'h002);
    look(3'd5, h);
    tick(10);
    look(3'd5, v); check(v == h, "R6 counter 2 holds", v, h);
    wr(3'd0, 12'h003);
    look(3'd5, v); check(v == h, "R6 no step on enable edge", v, h);
    tick(5);
    look(3'd5, v); check(v == h + 12'd5, "R6 resumes from held value", v, h + 12'd5);
  endtask

  task automatic t_route(input logic [47:0] d, input bit run, input string tag);
    logic [11:0] c1, c2;
    duty = d;
    wr(3'd0, {11'd0, run} | 12'h002);
    look(3'd4, c1); look(3'd5, c2);
    check(pwm == exp_pwm(c1, c2, run, 1'b0, 2'b11), tag, pwm, exp_pwm(c1, c2, run, 1'b0, 2'b11));
  endtask

  task automatic t_break(input bit run, input logic [1:0] be, input bit brk, input string tag);
    logic [11:0] c1, c2;
    duty = {12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF};
    wr(3'd3, {10'd0, be});
    wr(3'd0, {11'd0, run} | 12'h002);
    brk_in = brk;
    look(3'd4, c1); look(3'd5, c2);
    check(pwm == exp_pwm(c1, c2, run, brk, be), tag, pwm, exp_pwm(c1, c2, run, brk, be));
    brk_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_force1();
    t_force_zero_ignored();
    t_flag_irq();
    t_freeze();
    t_route({12'h800, 12'h000, 12'hFFF, 12'h400}, 1'b0, "R8 R9 pair2 from counter 1");
    t_route({12'h800, 12'h000, 12'hFFF, 12'h400}, 1'b1, "R8 R9 pair2 from counter 2");
    wr(3'd0, 12'h012);
    t_route({12'hFFF, 12'h001, 12'h000, 12'hFFF}, 1'b0, "R8 R9 counter 2 forced while stopped");
    t_route({12'h123, 12'hABC, 12'h555, 12'h0F0}, 1'b1, "R9 mixed duties");
    t_break(1'b1, 2'b11, 1'b1, "R10 all pairs gated");
    t_break(1'b1, 2'b01, 1'b1, "R10 pair2 uses enable 2");
    t_break(1'b0, 2'b10, 1'b1, "R10 pair2 uses enable 1 when stopped");
    t_break(1'b0, 2'b01, 1'b1, "R10 enable 1 gates both when stopped");
    t_break(1'b1, 2'b11, 1'b0, "R10 no break inactive");
    wr(3'd3, 12'hFFF);
    look(3'd3, v); check(v == 12'h003, "R7 upper bits read 0", v, 12'h003);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule